// File: doc/BRIEF.md
# Thermal Sensor Two-Wire Register Slave

This block is the serial-bus side of an on-chip temperature monitor. It acts as an I2C/SMBus slave. An 8-bit index register selects one of eight 16-bit words: a fixed feature word, a configuration word, three limit words (window high, window low and critical), the live temperature word, and two fixed identity words. The design samples SCL and SDA with the system clock. Any synchronisation and glitch filtering happens upstream. The block drives SDA only through a pull-down enable.

A host can reach the registers in four ways:
- Write the slave address and an index byte only, which moves the index.
- Write an index byte followed by a 16-bit value, sent high byte first.
- Read two bytes at the index already latched.
- Write the index, issue a repeated START, then read.

Setting a protection bit in the configuration word freezes the limit words and most of the configuration word until the next reset. The three low address bits come from pins. Their value is captured once, on the second transfer that matches the address, and pin changes after that are ignored. If SDA stays quiet for a programmable number of clock cycles, the slave lets go of the bus and waits for a fresh START.

Top module: `thermo_i2c_regs`

## Requirements
- R1: After reset, `sda_pull` is 0. The configuration and the three limit outputs are 0x0000. The index is 0, so a read without an index byte returns the feature word 0x001D.
- R2: The slave acknowledges only the 7-bit address formed as binary 0011 followed by the three address-pin bits (pin 2 first). For any other address it leaves SDA released.
- R3: A transfer of address (write) plus one index byte changes the index to bits 2:0 of that byte and modifies no register. Each later read that has no index byte returns the word at that index, high byte first.
- R4: A write transfer of address, index, high byte and low byte stores the 16-bit value in the selected register. Any bytes after the second data byte are acknowledged and discarded.
- R5: The sequence address-write, index, repeated START, address-read returns the selected word. The master may end the read with NACK, which makes the slave release SDA, or with ACK, after which the slave sends the same word again from its high byte.
- R6: Index 0 reads 0x001D, index 6 reads 0x11D4, index 7 reads 0x0800, and index 5 reads the live `temp_word` input. Writes to these four indices are acknowledged and change nothing.
- R7: The limit registers at indices 2, 3 and 4 keep only bits 12:2 of a written value. All their other bits read 0.
- R8: Configuration bit 6 blocks writes to indices 2 and 3, and bit 7 blocks writes to index 4. Once either bit is set it stays set until reset.
- R9: While bit 6 or bit 7 is set, configuration bits 3:0 and 10:9 keep their values. Bit 8 (shutdown) can be cleared but not set.
- R10: Configuration bits 15:11, 5 (clear-event, write-only) and 4 (event status) always read 0.
- R11: If SDA does not change for `TOUT_CYCLES` clock cycles during a transfer, the slave drops its pull-down. It then ignores SCL activity until the next START.
- R12: Before capture, the address compare uses the live pin values. On the address byte of the second matching transfer after reset, the pins are frozen, and later pin changes have no effect.
- R13: A STOP condition releases SDA on the next clock and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (wired bus level) |
| addr_pins | input | 3 | Low three bits of the slave address |
| temp_word | input | 16 | Live temperature word returned at index 5 |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_q | output | 16 | Configuration word |
| upper_q | output | 16 | Window high limit |
| lower_q | output | 16 | Window low limit |
| crit_q | output | 16 | Critical limit |

## Verification
The inactivity release is the hardest condition to reach from the pins. It only matters while the slave itself is holding SDA low, and a well-behaved master never stalls there. To set it up, the bench points the index at the feature word, whose high byte starts with a 0 bit, and begins a read. It then stops the clock with SCL low while the slave is driving that 0. The bench confirms that the pull-down drops once the quiet window has elapsed, that clocking without a START is then ignored, and that a new transfer succeeds. The frozen-address rule needs the pin values changed between the first and second matching transfers, so that check runs right after reset, before any other traffic.

// File: rtl/thi_pkg.sv
// Shared constants and types for the two-wire thermal register slave.
// Assumes the 7-bit bus address carries a fixed upper nibble.
package thi_pkg;
    localparam logic [3:0]  BUS_PREFIX = 4'b0011;
    localparam logic [15:0] FEAT_WORD  = 16'h001D;
    localparam logic [15:0] VEND_WORD  = 16'h11D4;
    localparam logic [15:0] PART_WORD  = 16'h0800;
    localparam logic [15:0] LIMIT_KEEP = 16'h1FFC;

    localparam logic [2:0] IX_FEAT  = 3'd0;
    localparam logic [2:0] IX_CFG   = 3'd1;
    localparam logic [2:0] IX_HIGH  = 3'd2;
    localparam logic [2:0] IX_LOW   = 3'd3;
    localparam logic [2:0] IX_CRIT  = 3'd4;
    localparam logic [2:0] IX_TEMP  = 3'd5;
    localparam logic [2:0] IX_VEND  = 3'd6;
    localparam logic [2:0] IX_PART  = 3'd7;

    typedef enum logic [2:0] {
        LK_IDLE, LK_ADDR, LK_AACK, LK_RX, LK_RACK, LK_TX, LK_TACK
    } link_state_t;
endpackage

// File: rtl/thi_bus_edges.sv
// Detects SCL edges and START/STOP from the sampled lines.
// Assumes scl_i/sda_i are already synchronous to clk and filtered.
module thi_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_chg
);
    logic scl_q, sda_q;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = !scl_q && scl_i;
    assign scl_fall  = scl_q && !scl_i;
    assign start_det = scl_q && scl_i && sda_q && !sda_i;
    assign stop_det  = scl_q && scl_i && !sda_q && sda_i;
    assign sda_chg   = sda_q ^ sda_i;
endmodule

// File: rtl/thi_link.sv
// Byte-level slave protocol: address match, index/data reception,
// word transmission, address-pin capture and SDA inactivity release.
// Assumes SDA changes are driven on SCL falling edges.
module thi_link #(
    parameter int TOUT_CYCLES = 5_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_i,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        sda_chg,
    input  logic [2:0]  addr_pins,
    input  logic [15:0] rd_data,
    output logic        sda_pull,
    output logic [2:0]  index,
    output logic        wr_en,
    output logic [15:0] wr_data
);
    import thi_pkg::*;
    localparam int TW = $clog2(TOUT_CYCLES + 1);

    link_state_t state;
    logic [3:0]  bit_cnt;
    logic [7:0]  sh, tx_sh, hi_hold;
    logic [1:0]  byte_idx;
    logic        hit, rw, lo_next, seen_once, frozen;
    logic [2:0]  pins_held;
    logic [TW-1:0] quiet;
    logic [7:0]  rx_byte;
    logic [2:0]  pins_sel;
    logic        addr_match, tout_hit;

    assign rx_byte    = {sh[6:0], sda_i};
    assign pins_sel   = frozen ? pins_held : addr_pins;
    assign addr_match = (rx_byte[7:1] == {BUS_PREFIX, pins_sel});
    assign tout_hit   = (state != LK_IDLE) && (quiet == TW'(TOUT_CYCLES));

    // Protocol sequencer with START/STOP/timeout overriding every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;  bit_cnt <= '0;  sh <= '0;  tx_sh <= '0;
            hi_hold <= '0;  byte_idx <= '0;  hit <= 1'b0;  rw <= 1'b0;
            lo_next <= 1'b0;  seen_once <= 1'b0;  frozen <= 1'b0;
            pins_held <= '0;  quiet <= '0;  sda_pull <= 1'b0;
            index <= '0;  wr_en <= 1'b0;  wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state <= LK_ADDR;  bit_cnt <= '0;  sda_pull <= 1'b0;  quiet <= '0;
            end else if (stop_det || tout_hit) begin
                state <= LK_IDLE;  sda_pull <= 1'b0;  quiet <= '0;
            end else begin
                quiet <= (state == LK_IDLE || sda_chg) ? '0 : quiet + 1'b1;
                case (state)
                    LK_ADDR: begin
                        if (scl_rise) begin
                            sh <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 4'd7) begin
                                hit <= addr_match;
                                rw  <= sda_i;
                                if (addr_match) begin
                                    seen_once <= 1'b1;
                                    if (seen_once && !frozen) begin
                                        frozen    <= 1'b1;
                                        pins_held <= addr_pins;
                                    end
                                end
                            end
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (hit) begin
                                sda_pull <= 1'b1;  state <= LK_AACK;  byte_idx <= '0;
                            end else begin
                                state <= LK_IDLE;
                            end
                        end
                    end
                    LK_AACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            tx_sh <= rd_data[15:8];  sda_pull <= ~rd_data[15];
                            lo_next <= 1'b1;  state <= LK_TX;
                        end else begin
                            sda_pull <= 1'b0;  state <= LK_RX;
                        end
                    end
                    LK_RX: begin
                        if (scl_rise) begin
                            sh <= rx_byte;  bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            sda_pull <= 1'b1;  state <= LK_RACK;
                            case (byte_idx)
                                2'd0:    index   <= sh[2:0];
                                2'd1:    hi_hold <= sh;
                                2'd2:    begin wr_en <= 1'b1; wr_data <= {hi_hold, sh}; end
                                default: ;
                            endcase
                            if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
                        end
                    end
                    LK_RACK: if (scl_fall) begin
                        sda_pull <= 1'b0;  bit_cnt <= '0;  state <= LK_RX;
                    end
                    LK_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_pull <= 1'b0;  state <= LK_TACK;
                            end else begin
                                tx_sh <= {tx_sh[6:0], 1'b0};  sda_pull <= ~tx_sh[6];
                            end
                        end
                    end
                    LK_TACK: begin
                        if (scl_rise && sda_i) begin
                            state <= LK_IDLE;
                        end else if (scl_fall) begin
                            tx_sh    <= lo_next ? rd_data[7:0] : rd_data[15:8];
                            sda_pull <= lo_next ? ~rd_data[7] : ~rd_data[15];
                            lo_next  <= ~lo_next;  bit_cnt <= '0;  state <= LK_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/thi_regbank.sv
// Register words behind the index: fixed words, configuration with
// sticky protection bits, and three masked limit words.
// Assumes wr_en is a single-cycle pulse from the link.
module thi_regbank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  index,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [15:0] temp_word,
    output logic [15:0] rd_data,
    output logic [15:0] cfg_q,
    output logic [15:0] upper_q,
    output logic [15:0] lower_q,
    output logic [15:0] crit_q
);
    import thi_pkg::*;

    logic [3:0] ev_ctl;
    logic [1:0] hyst;
    logic       shdn, win_prot, crit_prot, prot;

    assign prot  = win_prot | crit_prot;
    assign cfg_q = {5'b0, hyst, shdn, crit_prot, win_prot, 2'b00, ev_ctl};

    // Apply host writes under the protection rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_ctl <= '0;  hyst <= '0;  shdn <= 1'b0;
            win_prot <= 1'b0;  crit_prot <= 1'b0;
            upper_q <= '0;  lower_q <= '0;  crit_q <= '0;
        end else if (wr_en) begin
            case (index)
                IX_CFG: begin
                    win_prot  <= win_prot  | wr_data[6];
                    crit_prot <= crit_prot | wr_data[7];
                    if (prot) begin
                        shdn <= shdn & wr_data[8];
                    end else begin
                        shdn   <= wr_data[8];
                        ev_ctl <= wr_data[3:0];
                        hyst   <= wr_data[10:9];
                    end
                end
                IX_HIGH: if (!win_prot)  upper_q <= wr_data & LIMIT_KEEP;
                IX_LOW:  if (!win_prot)  lower_q <= wr_data & LIMIT_KEEP;
                IX_CRIT: if (!crit_prot) crit_q  <= wr_data & LIMIT_KEEP;
                default: ;
            endcase
        end
    end

    // Select the word the link transmits.
    always_comb begin
        case (index)
            IX_FEAT: rd_data = FEAT_WORD;
            IX_CFG:  rd_data = cfg_q;
            IX_HIGH: rd_data = upper_q;
            IX_LOW:  rd_data = lower_q;
            IX_CRIT: rd_data = crit_q;
            IX_TEMP: rd_data = temp_word;
            IX_VEND: rd_data = VEND_WORD;
            default: rd_data = PART_WORD;
        endcase
    end
endmodule

// File: rtl/thermo_i2c_regs.sv
// Top level of the two-wire thermal register slave: edge detection,
// protocol link and register bank. SDA is driven open-drain via sda_pull.
module thermo_i2c_regs #(
    parameter int TOUT_CYCLES = 5_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  addr_pins,
    input  logic [15:0] temp_word,
    output logic        sda_pull,
    output logic [15:0] cfg_q,
    output logic [15:0] upper_q,
    output logic [15:0] lower_q,
    output logic [15:0] crit_q
);
    logic        scl_rise, scl_fall, start_det, stop_det, sda_chg;
    logic [2:0]  index;
    logic        wr_en;
    logic [15:0] wr_data, rd_data;

    thi_bus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_chg(sda_chg)
    );

    thi_link #(.TOUT_CYCLES(TOUT_CYCLES)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_chg(sda_chg), .addr_pins(addr_pins), .rd_data(rd_data),
        .sda_pull(sda_pull), .index(index), .wr_en(wr_en), .wr_data(wr_data)
    );

    thi_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .index(index), .wr_en(wr_en),
        .wr_data(wr_data), .temp_word(temp_word), .rd_data(rd_data),
        .cfg_q(cfg_q), .upper_q(upper_q), .lower_q(lower_q), .crit_q(crit_q)
    );
endmodule

// File: rtl/thermo_i2c_regs_chk.sv
// Property checker for thermo_i2c_regs, attached by bind.
// Watches only the top-level ports; the quiet window is counted locally.
module thermo_i2c_regs_chk #(
    parameter int TOUT_CYCLES = 5_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_i,
    input logic        sda_pull,
    input logic [15:0] cfg_q,
    input logic [15:0] upper_q,
    input logic [15:0] lower_q,
    input logic [15:0] crit_q
);
    localparam int CW = $clog2(TOUT_CYCLES + 4) + 1;
    logic [CW-1:0] still_cnt;
    logic          sda_prev;

    // Count clocks since SDA last moved (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            still_cnt <= '0;
            sda_prev  <= 1'b1;
        end else begin
            sda_prev <= sda_i;
            if (sda_i != sda_prev) still_cnt <= '0;
            else if (still_cnt != {CW{1'b1}}) still_cnt <= still_cnt + 1'b1;
        end
    end

    p_stop_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !sda_pull);

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_q[6]) |-> cfg_q[6]) and ($past(cfg_q[7]) |-> cfg_q[7]));

    p_window_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q[6]) |-> ($stable(upper_q) && $stable(lower_q)));

    p_crit_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q[7]) |-> $stable(crit_q));

    p_fields_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q[6] | cfg_q[7]) |->
            (cfg_q[3:0] == $past(cfg_q[3:0]) && cfg_q[10:9] == $past(cfg_q[10:9])
             && !$rose(cfg_q[8])));

    p_quiet_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (still_cnt > CW'(TOUT_CYCLES + 2)) |-> !sda_pull);
endmodule

bind thermo_i2c_regs thermo_i2c_regs_chk #(.TOUT_CYCLES(TOUT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_pull(sda_pull), .cfg_q(cfg_q), .upper_q(upper_q),
    .lower_q(lower_q), .crit_q(crit_q)
);

// File: tb/thermo_i2c_regs_test.sv
// Directed bench: a bus master model drives SCL/SDA through tasks,
// one task per scenario, each checking its own results.
module thermo_i2c_regs_test;
    localparam int TOUT = 1500;
    localparam int H    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  pins = 3'b000;
    logic [15:0] temp_word = 16'h0000;
    logic        sda_pull, bus_sda;
    logic [15:0] cfg_q, upper_q, lower_q, crit_q;
    int          checks = 0;
    int          fails = 0;
    logic [6:0]  dev = 7'h1D;

    assign bus_sda = m_sda & ~sda_pull;

    always #5 clk = ~clk;

    thermo_i2c_regs #(.TOUT_CYCLES(TOUT)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .addr_pins(pins), .temp_word(temp_word), .sda_pull(sda_pull),
        .cfg_q(cfg_q), .upper_q(upper_q), .lower_q(lower_q), .crit_q(crit_q)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic put_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
        end
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
        ack = !bus_sda;
        wt(H/2); m_scl = 1'b0;
    endtask

    task automatic get_byte(logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); m_scl = 1'b1; wt(H/2); b[i] = bus_sda; wt(H/2); m_scl = 1'b0;
        end
        m_sda = !mack; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic reg_write(logic [2:0] ix, logic [15:0] d);
        logic a;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte({5'b0, ix}, a);
        put_byte(d[15:8], a); put_byte(d[7:0], a); bus_stop();
    endtask

    task automatic set_index(logic [2:0] ix);
        logic a;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte({5'b0, ix}, a); bus_stop();
    endtask

    task automatic read_cur(logic [6:0] adr, output logic ack, output logic [15:0] d);
        bus_start(); put_byte({adr, 1'b1}, ack);
        if (ack) begin
            get_byte(1'b1, d[15:8]); get_byte(1'b0, d[7:0]);
        end else d = 16'hxxxx;
        bus_stop();
    endtask

    task automatic read_at(logic [2:0] ix, output logic [15:0] d);
        logic a;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte({5'b0, ix}, a);
        bus_start(); put_byte({dev, 1'b1}, a);
        get_byte(1'b1, d[15:8]); get_byte(1'b0, d[7:0]); bus_stop();
    endtask

    task automatic t_reset();
        logic a; logic [15:0] d;
        chk("R1 sda_pull", 16'(sda_pull), 16'h0);
        chk("R1 cfg", cfg_q, 16'h0);
        chk("R1 limits", upper_q | lower_q | crit_q, 16'h0);
        read_cur(7'h18, a, d);
        chk("R1 index0 read", d, 16'h001D);
    endtask

    task automatic t_addr_pins();
        logic a; logic [15:0] d;
        pins = 3'b101;
        bus_start(); put_byte({7'h18, 1'b1}, a); bus_stop();
        chk("R12 live pins before capture", 16'(a), 16'h0);
        bus_start(); put_byte({7'h48, 1'b1}, a); bus_stop();
        chk("R2 wrong prefix ignored", 16'(a), 16'h0);
        read_cur(7'h1D, a, d);
        chk("R12 second match acked", 16'(a), 16'h1);
        pins = 3'b010;
        bus_start(); put_byte({7'h1A, 1'b1}, a); bus_stop();
        chk("R12 new pins ignored", 16'(a), 16'h0);
        read_cur(7'h1D, a, d);
        chk("R12 frozen address", 16'(a), 16'h1);
        chk("R2 data", d, 16'h001D);
    endtask

    task automatic t_index();
        logic a; logic [15:0] d;
        set_index(3'd6);
        chk("R3 index-only write", cfg_q | upper_q, 16'h0);
        read_cur(dev, a, d);
        chk("R3 read at index 6", d, 16'h11D4);
        read_cur(dev, a, d);
        chk("R3 index kept", d, 16'h11D4);
        set_index(3'd7);
        read_cur(dev, a, d);
        chk("R6 index 7", d, 16'h0800);
    endtask

    task automatic t_write();
        logic a; logic [15:0] d;
        reg_write(3'd2, 16'hFFFF);
        chk("R7 upper mask", upper_q, 16'h1FFC);
        bus_start(); put_byte({dev, 1'b0}, a); put_byte(8'h03, a);
        put_byte(8'h01, a); put_byte(8'h23, a); put_byte(8'hAB, a);
        chk("R4 extra byte acked", 16'(a), 16'h1);
        put_byte(8'hCD, a); bus_stop();
        chk("R4 extra bytes dropped", lower_q, 16'h0120);
        read_at(3'd2, d);
        chk("R5 repeated-start read", d, 16'h1FFC);
        read_at(3'd3, d);
        chk("R5 repeated-start read low", d, 16'h0120);
    endtask

    task automatic t_ack_end();
        logic a; logic [15:0] d;
        temp_word = 16'h9234;
        bus_start(); put_byte({dev, 1'b0}, a); put_byte(8'h05, a);
        bus_start(); put_byte({dev, 1'b1}, a);
        get_byte(1'b1, d[15:8]); get_byte(1'b1, d[7:0]); bus_stop();
        chk("R5 ack-terminated read", d, 16'h9234);
        chk("R13 released after stop", 16'(sda_pull), 16'h0);
        read_cur(dev, a, d);
        chk("R5 next read after ack end", d, 16'h9234);
    endtask

    task automatic t_readonly();
        logic a; logic [15:0] d;
        reg_write(3'd0, 16'h1234);
        read_at(3'd0, d);  chk("R6 feature fixed", d, 16'h001D);
        reg_write(3'd7, 16'hFFFF);
        read_at(3'd7, d);  chk("R6 part fixed", d, 16'h0800);
        reg_write(3'd6, 16'h0000);
        read_at(3'd6, d);  chk("R6 vendor fixed", d, 16'h11D4);
        temp_word = 16'h0190;
        reg_write(3'd5, 16'h5555);
        read_at(3'd5, d);  chk("R6 temp live", d, 16'h0190);
        temp_word = 16'h1E74;
        read_cur(dev, a, d); chk("R6 temp follows input", d, 16'h1E74);
    endtask

    task automatic t_cfg();
        logic [15:0] d;
        reg_write(3'd1, 16'hF93F);
        chk("R10 reserved/status/clear read 0", cfg_q, 16'h010F);
        read_at(3'd1, d);
        chk("R10 bus readback", d, 16'h010F);
        reg_write(3'd1, 16'h060A);
        chk("R10 cfg store", cfg_q, 16'h060A);
    endtask

    task automatic t_lock();
        reg_write(3'd2, 16'h0100); reg_write(3'd3, 16'h0050); reg_write(3'd4, 16'h0200);
        reg_write(3'd1, 16'h070A);
        chk("R9 shutdown set unlocked", cfg_q, 16'h070A);
        reg_write(3'd1, 16'h074A);
        chk("R8 window lock set", cfg_q, 16'h074A);
        reg_write(3'd2, 16'h0444);
        chk("R8 upper locked", upper_q, 16'h0100);
        reg_write(3'd3, 16'h0444);
        chk("R8 lower locked", lower_q, 16'h0050);
        reg_write(3'd4, 16'h0300);
        chk("R8 crit still open", crit_q, 16'h0300);
        reg_write(3'd1, 16'h0005);
        chk("R9 fields held, shutdown cleared", cfg_q, 16'h064A);
        reg_write(3'd1, 16'h0100);
        chk("R9 shutdown not set", cfg_q, 16'h064A);
        reg_write(3'd1, 16'h0080);
        chk("R8 crit lock set", cfg_q, 16'h06CA);
        reg_write(3'd4, 16'h0400);
        chk("R8 crit locked", crit_q, 16'h0300);
        pins = 3'b101;
        rst_n = 1'b0; wt(4); rst_n = 1'b1; wt(4);
        chk("R8 reset clears locks", cfg_q, 16'h0000);
        reg_write(3'd2, 16'h0123);
        chk("R8 unlocked after reset", upper_q, 16'h0120);
    endtask

    task automatic t_timeout();
        logic a; logic [15:0] d; logic any_pull;
        set_index(3'd0);
        bus_start(); put_byte({dev, 1'b1}, a);
        wt(H);
        chk("R11 slave holding low", 16'(bus_sda), 16'h0);
        wt(TOUT + 200);
        chk("R11 released after quiet window", 16'(sda_pull), 16'h0);
        any_pull = 1'b0;
        m_sda = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
            any_pull |= sda_pull;
        end
        chk("R11 ignores clocks until START", 16'(any_pull), 16'h0);
        m_scl = 1'b1; wt(H);
        read_cur(dev, a, d);
        chk("R11 recovers on START", d, 16'h001D);
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(3);
        t_reset();
        t_addr_pins();
        t_index();
        t_write();
        t_ack_end();
        t_readonly();
        t_cfg();
        t_lock();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule